// File: doc/BRIEF.md
# Dual-Clock Latched Shift Register with Open-Drain Outputs

This block takes data one bit at a time into an 8-stage shift chain on the rising edge of a shift clock. A separate latch clock copies the whole chain into a parallel holding register. Each holding bit drives an open-drain pad. A stored 1 pulls its pad low, and a stored 0 leaves the pad floating, so a board-level pull-up reads it high. An active-low enable floats every pad at once and leaves both registers as they were.

The last stage of the chain is re-registered on the falling edge of the shift clock and appears on a cascade pin. The cascade pin of one instance can feed the serial input of the next with half a clock of hold margin, so several instances form one long chain. An active-low asynchronous clear empties the chain, the holding register and the cascade register, with no clock needed. If both clocks are tied together, the holding register always shows the chain as it stood one edge earlier.

Top module: `dcsr_top`

## Requirements
- R1: While `clr_n` is low, the shift chain, the holding register and `ser_out` are all 0, so with `oe_n` low every pad reads high through an external pull-up.
- R2: On each rising `sclk` edge, `ser_in` enters stage 0 and each stage k moves to stage k+1. Stage 7 is the oldest bit.
- R3: On each rising `lclk` edge, the shift chain is copied into the holding register. Rising `sclk` edges alone do not change the pads.
- R4: While `oe_n` is high, all eight pads are high impedance. Changing `oe_n` alters neither register, so re-enabling shows the same pattern as before.
- R5: Pulling `clr_n` low clears every register at once, with no clock edge.
- R6: `ser_out` equals stage 7 of the chain. It changes only on the falling `sclk` edge, so during the high phase after a rising edge it still shows the stage-7 value from before that edge.
- R7: When `sclk` and `lclk` rise together, the holding register captures the chain value from before that edge.
- R8: Pad i (`pad_o[i]`) follows holding bit i. While enabled, the pad is driven 0 when the bit is 1 and is high impedance when the bit is 0.
- R9: When two instances are chained through `ser_out` into `ser_in`, 16 shift edges and one latch edge put the 16 bits on the pads. The first bit shifted in lands on bit 7 of the downstream instance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Shift clock; the chain moves on the rising edge, `ser_out` updates on the falling edge |
| lclk | input | 1 | Latch clock; copies the chain into the holding register on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| oe_n | input | 1 | Pad enable, active low; high floats all pads |
| ser_out | output | 1 | Cascade output, stage 7 retimed on the falling `sclk` edge |
| pad_o | output | 8 | Open-drain pads, driven 0 for a held 1, high impedance otherwise |

## Verification
Two functions can land on the same edge: the chain shifting and the holding register latching, when `sclk` and `lclk` are driven by one signal. The bench runs a stretch with both clocks rising in the same instant. Its model copies the chain before shifting it, and the pads are compared against that pre-edge copy. Separately, `ser_out` is sampled in the high phase of `sclk`, where a rising-edge retime would already show the new stage-7 value.

// File: rtl/dcsr_pkg.sv
// Package: shared width and vector type for the dual-clock latched shifter.
// Assumes: every submodule sizes itself from DCSR_W unless overridden.
package dcsr_pkg;
    localparam int DCSR_W = 8;
    typedef logic [DCSR_W-1:0] dcsr_vec_t;
endpackage

// File: rtl/dcsr_shift.sv
// Module: serial shift chain plus a cascade register clocked on the falling edge.
// Assumes: clr_n is released away from sclk edges; W >= 2.
module dcsr_shift #(
    parameter int W = dcsr_pkg::DCSR_W
) (
    input  logic         sclk,
    input  logic         clr_n,
    input  logic         ser_in,
    output logic [W-1:0] stage_q,
    output logic         ser_out
);
    localparam int TOP = W - 1;

    logic casc_q;
    logic seen_s;

    // Shift the chain toward the top stage on each rising sclk edge.
    always_ff @(posedge sclk or negedge clr_n) begin
        if (!clr_n) stage_q <= '0;
        else        stage_q <= {stage_q[TOP-1:0], ser_in};
    end

    // Retime the top stage on the falling edge for extra hold at the next stage.
    always_ff @(negedge sclk or negedge clr_n) begin
        if (!clr_n) casc_q <= 1'b0;
        else        casc_q <= stage_q[TOP];
    end

    assign ser_out = casc_q;

    // Checker state: set once a rising edge has passed since the last clear.
    always_ff @(posedge sclk or negedge clr_n) begin
        if (!clr_n) seen_s <= 1'b0;
        else        seen_s <= 1'b1;
    end

    // R2
    shift_order_chk: assert property (@(posedge sclk) disable iff (!clr_n)
        seen_s |-> (stage_q[1] == $past(stage_q[0])));

    // R6
    casc_hold_chk: assert property (@(posedge sclk) disable iff (!clr_n)
        ser_out == stage_q[TOP]);

    // R5
    chain_clear_chk: assert property (@(posedge sclk) disable iff (!clr_n)
        !seen_s |-> (stage_q == '0));
endmodule

// File: rtl/dcsr_store.sv
// Module: parallel holding register loaded from the shift chain on lclk.
// Assumes: the chain value is stable around each rising lclk edge, or lclk is tied to sclk.
module dcsr_store #(
    parameter int W = dcsr_pkg::DCSR_W
) (
    input  logic         lclk,
    input  logic         clr_n,
    input  logic [W-1:0] chain_d,
    output logic [W-1:0] hold_q
);
    logic seen_l;

    // Capture the whole chain on each rising lclk edge.
    always_ff @(posedge lclk or negedge clr_n) begin
        if (!clr_n) hold_q <= '0;
        else        hold_q <= chain_d;
    end

    // Checker state: set once a latch edge has passed since the last clear.
    always_ff @(posedge lclk or negedge clr_n) begin
        if (!clr_n) seen_l <= 1'b0;
        else        seen_l <= 1'b1;
    end

    // R3
    hold_copy_chk: assert property (@(posedge lclk) disable iff (!clr_n)
        seen_l |-> (hold_q == $past(chain_d)));

    // R1
    hold_clear_chk: assert property (@(posedge lclk) disable iff (!clr_n)
        !seen_l |-> (hold_q == '0));
endmodule

// File: rtl/dcsr_odrv.sv
// Module: open-drain pad drivers, one per holding bit.
// Assumes: an external pull-up defines the released level.
module dcsr_odrv #(
    parameter int W = dcsr_pkg::DCSR_W
) (
    input  logic         oe_n,
    input  logic [W-1:0] hold_d,
    output logic [W-1:0] pad_o
);
    logic [W-1:0] sink;

    // Sink a pad only when enabled and its bit is set.
    always_comb begin
        sink = oe_n ? '0 : hold_d;
    end

    for (genvar i = 0; i < W; i++) begin : g_pad
        // Drive low or release; never drive high.
        assign pad_o[i] = sink[i] ? 1'b0 : 1'bz;
    end
endmodule

// File: rtl/dcsr_top.sv
// Module: dual-clock latched shift register with open-drain parallel pads.
// Assumes: sclk and lclk may be the same net; clr_n is released away from clock edges.
module dcsr_top #(
    parameter int W = dcsr_pkg::DCSR_W
) (
    input  logic         sclk,
    input  logic         lclk,
    input  logic         clr_n,
    input  logic         ser_in,
    input  logic         oe_n,
    output logic         ser_out,
    output logic [W-1:0] pad_o
);
    logic [W-1:0] chain;
    logic [W-1:0] held;

    dcsr_shift #(.W(W)) u_shift (
        .sclk    (sclk),
        .clr_n   (clr_n),
        .ser_in  (ser_in),
        .stage_q (chain),
        .ser_out (ser_out)
    );

    dcsr_store #(.W(W)) u_store (
        .lclk    (lclk),
        .clr_n   (clr_n),
        .chain_d (chain),
        .hold_q  (held)
    );

    dcsr_odrv #(.W(W)) u_odrv (
        .oe_n   (oe_n),
        .hold_d (held),
        .pad_o  (pad_o)
    );
endmodule

// File: tb/sim_dcsr_top.sv
// Bench: two chained instances, pull-ups on all pads, model-based checks.
module sim_dcsr_top;
    logic clk = 1'b0;
    logic sclk = 1'b0;
    logic lclk = 1'b0;
    logic clr_n = 1'b0;
    logic din = 1'b0;
    logic oe_n = 1'b0;
    logic so0;
    logic so1;
    wire [7:0] pads0;
    wire [7:0] pads1;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic [15:0] m_chain = '0;
    logic [15:0] m_hold = '0;
    logic m_so0 = 1'b0;
    logic m_so1 = 1'b0;

    always #10 clk = ~clk;

    for (genvar i = 0; i < 8; i++) begin : g_pu
        pullup (pads0[i]);
        pullup (pads1[i]);
    end

    dcsr_top u0 (.sclk(sclk), .lclk(lclk), .clr_n(clr_n), .ser_in(din),
                 .oe_n(oe_n), .ser_out(so0), .pad_o(pads0));
    dcsr_top u1 (.sclk(sclk), .lclk(lclk), .clr_n(clr_n), .ser_in(so0),
                 .oe_n(oe_n), .ser_out(so1), .pad_o(pads1));

    function automatic logic [15:0] exp_pads(input logic [15:0] hold, input logic off);
        return off ? 16'hFFFF : ~hold;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_pads(input string req);
        check(req, {pads1, pads0}, exp_pads(m_hold, oe_n));
    endtask

    // One shift pulse; tied also raises lclk in the same instant.
    task automatic shift_bit(input logic d, input logic tied, input string req);
        @(negedge clk);
        din = d;
        @(posedge clk);
        sclk = 1'b1;
        if (tied) lclk = 1'b1;
        if (tied) m_hold = m_chain;
        m_chain = {m_chain[14:0], d};
        @(negedge clk);
        check("R6 hold in high phase", {14'd0, so1, so0}, {14'd0, m_so1, m_so0});
        sclk = 1'b0;
        lclk = 1'b0;
        m_so0 = m_chain[7];
        m_so1 = m_chain[15];
        @(posedge clk);
        #2;
        check("R6 falling update", {14'd0, so1, so0}, {14'd0, m_so1, m_so0});
        check_pads(req);
    endtask

    task automatic latch();
        @(negedge clk);
        lclk = 1'b1;
        m_hold = m_chain;
        @(posedge clk);
        lclk = 1'b0;
        #2;
        check_pads("R3 latch copy");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] seq;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        check("R1 reset pads", {pads1, pads0}, 16'hFFFF);
        check("R1 reset ser_out", {14'd0, so1, so0}, 16'd0);
        @(negedge clk);
        clr_n = 1'b1;
        repeat (2) @(posedge clk);

        // R2 directed pattern then latch
        for (int i = 0; i < 8; i++) shift_bit(1'(8'hA5 >> (7 - i)), 1'b0, "R3 sclk alone");
        latch();
        check("R2 order 8'hA5", {8'd0, ~pads0}, 16'h00A5);

        // R2/R8 random stimulus with occasional latches
        for (int i = 0; i < 60; i++) begin
            shift_bit(1'($urandom), 1'b0, "R3 sclk alone");
            if ($urandom % 4 == 0) latch();
        end
        latch();
        check_pads("R8 pad per bit");

        // R4 enable floats pads, registers untouched
        @(negedge clk);
        oe_n = 1'b1;
        #2;
        check("R4 disabled pads", {pads1, pads0}, 16'hFFFF);
        shift_bit(1'b1, 1'b0, "R4 shift while off");
        @(negedge clk);
        oe_n = 1'b0;
        #2;
        check_pads("R4 re-enable");

        // R7 tied clocks
        for (int i = 0; i < 20; i++) shift_bit(1'($urandom), 1'b1, "R7 tied lag");

        // R5 asynchronous clear with no clock
        @(negedge clk);
        #3;
        clr_n = 1'b0;
        #2;
        m_chain = '0; m_hold = '0; m_so0 = 1'b0; m_so1 = 1'b0;
        check("R5 async clear pads", {pads1, pads0}, 16'hFFFF);
        check("R5 async clear ser_out", {14'd0, so1, so0}, 16'd0);
        @(negedge clk);
        clr_n = 1'b1;
        latch();
        check("R5 chain empty", {pads1, pads0}, 16'hFFFF);

        // R9 cascade of 16 bits
        for (int r = 0; r < 3; r++) begin
            seq = 16'($urandom);
            if (r == 0) seq = 16'h8001;
            for (int i = 15; i >= 0; i--) shift_bit(seq[i], 1'b0, "R3 sclk alone");
            latch();
            check("R9 cascade", ~{pads1, pads0}, seq);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule